// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Entry Unit

This unit decides, every clock, whether the hart must leave its current instruction stream and where it must go. It looks at the pending and enabled interrupt lines, the two delegation masks, the current privilege level and the interrupt-enable and stacking bits of the machine status register, together with a synchronous exception request that carries a cause index and a trap value. When a trap is taken, it produces the redirect target, the new privilege level, the cause, exception PC and trap value to be written into the machine-level or supervisor-level trap registers, and the updated status stacking bits.

Selection follows a fixed order. Interrupt lines above the machine external position are implementation-specific and beat every standard line; among the standard lines the order is fixed. Supervisor-level interrupts are looked at only when no machine-level interrupt qualifies. A debug-mode input masks all interrupts and sends every exception to one of two fixed debug addresses without touching any register. A breakpoint raised at a privilege level whose breakpoint-to-debug enable is set enters debug mode instead of trapping. The block holds no architectural state of its own: the CSR file consumes its write strobes one cycle after the request.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted, redirect_o, m_wr_o, s_wr_o and dbg_wr_o are 0, new_priv_o is 3 (M), and all other outputs are 0. Privilege codes are U=0, S=1, M=3.
- R2: An interrupt line is a machine-level candidate when it is pending, enabled and its bit in irq_deleg_i is 0, and the current privilege is not M or ms_mie_i is 1; at M with ms_mie_i 0 such a line is not taken.
- R3: A delegated, pending, enabled line is a supervisor-level candidate only when no machine-level candidate exists, and only when the privilege is U, or S with ms_sie_i set.
- R4: While debug_mode_i is 1 no interrupt is taken.
- R5: Candidate bits at index 12 and above win over all others, the lowest such index first; otherwise the order is 11 (machine external), 3 (machine software), 7 (machine timer), 9 (supervisor external), 1 (supervisor software), 5 (supervisor timer). Bits 0, 2, 4, 6, 8, 10 are never taken.
- R6: An interrupt reports a cause equal to its bit index with bit 31 set and a trap value of 0; an exception reports exc_cause_i zero-extended with bit 31 clear and exc_tval_i; epc_o takes cur_pc_i in both cases.
- R7: A trap goes to S (s_wr_o, new_priv_o=1) when the privilege is U or S and the bit of exc_deleg_i (exceptions) or irq_deleg_i (interrupts) at the cause index is 1; otherwise it goes to M (m_wr_o, new_priv_o=3).
- R8: The redirect target is the selected vector register (stvec_i for S, mtvec_i for M) with bit 0 cleared, plus 4 times the cause index only when bit 0 of that register is 1 and the trap is an interrupt.
- R9: On M entry ms_mpie_o takes ms_mie_i, ms_mpp_o the old privilege and ms_mie_o becomes 0; on S entry ms_spie_o takes ms_sie_i, ms_spp_o bit 0 of the old privilege and ms_sie_o becomes 0. Bits of the other level pass through from the inputs.
- R10: In debug mode an exception with cause 3 (breakpoint) redirects to DBG_ROM_ENTRY and any other cause to DBG_EXC_VEC; no write strobe is raised, new_priv_o equals the current privilege, and the held register outputs keep their values.
- R11: Outside debug mode, a cause-3 exception at M with ebrk_m_i, at S with ebrk_s_i, or at U with ebrk_u_i raises dbg_wr_o, redirects to DBG_ROM_ENTRY, sets new_priv_o to 3, epc_o to cur_pc_i, dbg_prv_o to the old privilege and dbg_cause_o to 1.
- R12: Every result appears exactly one clock after the request is sampled and redirect_o is high for that one cycle per requesting cycle; an interrupt present together with an exception request wins; without any request redirect_o and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | IRQ_W | Pending interrupt lines |
| irq_en_i | input | IRQ_W | Per-line interrupt enables |
| irq_deleg_i | input | IRQ_W | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask, indexed by cause |
| cur_priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_pc_i | input | XLEN | PC of the instruction being trapped |
| ms_mie_i | input | 1 | Machine interrupt enable |
| ms_sie_i | input | 1 | Supervisor interrupt enable |
| ms_mpie_i | input | 1 | Machine previous interrupt enable |
| ms_spie_i | input | 1 | Supervisor previous interrupt enable |
| ms_mpp_i | input | 2 | Machine previous privilege |
| ms_spp_i | input | 1 | Supervisor previous privilege |
| mtvec_i | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| stvec_i | input | XLEN | Supervisor trap vector, bit 0 selects vectored mode |
| debug_mode_i | input | 1 | Hart is in debug mode |
| ebrk_m_i | input | 1 | Breakpoint at M enters debug |
| ebrk_s_i | input | 1 | Breakpoint at S enters debug |
| ebrk_u_i | input | 1 | Breakpoint at U enters debug |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | log2(XLEN) | Exception cause index |
| exc_tval_i | input | XLEN | Exception trap value |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | XLEN | New PC |
| new_priv_o | output | 2 | Privilege after the trap |
| m_wr_o | output | 1 | Write machine trap registers and status |
| s_wr_o | output | 1 | Write supervisor trap registers and status |
| dbg_wr_o | output | 1 | Write debug PC and debug control fields |
| cause_o | output | XLEN | Cause value |
| epc_o | output | XLEN | Saved PC (also the debug PC on debug entry) |
| tval_o | output | XLEN | Trap value |
| ms_mie_o | output | 1 | Updated machine interrupt enable |
| ms_sie_o | output | 1 | Updated supervisor interrupt enable |
| ms_mpie_o | output | 1 | Updated machine previous interrupt enable |
| ms_spie_o | output | 1 | Updated supervisor previous interrupt enable |
| ms_mpp_o | output | 2 | Updated machine previous privilege |
| ms_spp_o | output | 1 | Updated supervisor previous privilege |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |
| dbg_cause_o | output | 3 | Debug entry cause (1 = software breakpoint) |

## Verification
Every output of this unit is a register loaded from inputs sampled at one rising edge, so each result, the strobes and the redirect target alike, is due exactly one clock after the cycle that presents the request. The bench changes all inputs just after a falling edge and compares at the following falling edge, half a period after the edge that loads the result and half a period before the next one. Held outputs (cause, saved PC, trap value, status bits, debug fields) are compared every cycle against values the bench model keeps from its last trap, which is what exposes writes that should not have happened in idle or debug-mode cycles.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [1:0] {
      PRV_U   = 2'd0,
      PRV_S   = 2'd1,
      PRV_RSV = 2'd2,
      PRV_M   = 2'd3
   } priv_e;

   // Standard interrupt line positions; these are decoded by the CSR file.
   localparam int IRQ_SSI = 1;
   localparam int IRQ_MSI = 3;
   localparam int IRQ_STI = 5;
   localparam int IRQ_MTI = 7;
   localparam int IRQ_SEI = 9;
   localparam int IRQ_MEI = 11;

   // First implementation-specific line.
   localparam int NONSTD_BASE = IRQ_MEI + 1;

   // Standard lines from highest to lowest priority.
   localparam int STD_COUNT = 6;
   localparam int STD_ORDER [STD_COUNT] =
      '{IRQ_MEI, IRQ_MSI, IRQ_MTI, IRQ_SEI, IRQ_SSI, IRQ_STI};

   localparam int          EXC_BREAK      = 3;
   localparam logic [2:0]  DBG_CAUSE_SWBP = 3'd1;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import trap_pkg::*;
#(
   parameter int IRQ_W = 16,
   parameter int IDX_W = 5
)(
   input  logic [IRQ_W-1:0] pend_i,
   input  logic [IRQ_W-1:0] en_i,
   input  logic [IRQ_W-1:0] deleg_i,
   input  logic [1:0]       priv_i,
   input  logic             mie_i,
   input  logic             sie_i,
   input  logic             debug_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);

   logic             m_on, s_on;
   logic [IRQ_W-1:0] live, cand_m, cand_s, cand;
   logic [IRQ_W-1:0] ns_gnt, ns_seen, gnt;

   // Level enables: machine level is open below M or with MIE; supervisor
   // level is open in U, or in S with SIE.
   assign m_on = (priv_i != PRV_M) || mie_i;
   assign s_on = (priv_i == PRV_U) || ((priv_i == PRV_S) && sie_i);

   assign live   = pend_i & en_i;
   assign cand_m = live & ~deleg_i & {IRQ_W{m_on}};
   assign cand_s = live &  deleg_i & {IRQ_W{s_on}};

   always_comb begin
      if (debug_i)
         cand = '0;
      else if (cand_m != '0)
         cand = cand_m;
      else
         cand = cand_s;
   end

   // Lowest-index wins among implementation-specific lines: a ripple of
   // "something below already seen" flags.
   assign ns_gnt [NONSTD_BASE-1:0] = '0;
   assign ns_seen[NONSTD_BASE-1:0] = '0;

   for (genvar b = NONSTD_BASE; b < IRQ_W; b++) begin : g_nonstd
      assign ns_gnt[b]  = cand[b] & ~ns_seen[b-1];
      assign ns_seen[b] = cand[b] |  ns_seen[b-1];
   end

   always_comb begin
      gnt = ns_gnt;
      if (ns_gnt == '0) begin
         for (int k = 0; k < STD_COUNT; k++) begin
            if ((gnt == '0) && cand[STD_ORDER[k]])
               gnt[STD_ORDER[k]] = 1'b1;
         end
      end
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < IRQ_W; i++) begin
         if (gnt[i])
            idx_o = IDX_W'(i);
      end
   end

   assign valid_o = (gnt != '0);

   always_comb begin
      assert_grant_onehot_R5: assert ($onehot0(gnt));
      assert_grant_in_cand_R5: assert ((gnt & ~live) == '0);
      assert_no_irq_in_debug_R4: assert (!(debug_i && valid_o));
   end

endmodule

// File: rtl/trap_router.sv
module trap_router
   import trap_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
)(
   input  logic             is_irq_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [1:0]       priv_i,
   input  logic [XLEN-1:0]  deleg_i,
   input  logic [XLEN-1:0]  mtvec_i,
   input  logic [XLEN-1:0]  stvec_i,
   output logic             to_s_o,
   output logic [XLEN-1:0]  pc_o
);

   logic [XLEN-1:0] tvec, base, offset;

   assign to_s_o = ((priv_i == PRV_U) || (priv_i == PRV_S)) && deleg_i[idx_i];
   assign tvec   = to_s_o ? stvec_i : mtvec_i;
   assign base   = {tvec[XLEN-1:1], 1'b0};
   assign offset = (tvec[0] && is_irq_i) ? XLEN'({idx_i, 2'b00}) : '0;
   assign pc_o   = base + offset;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int               XLEN          = 32,
   parameter int               IRQ_W         = 16,
   parameter logic [XLEN-1:0]  DBG_ROM_ENTRY = 'h800,
   parameter logic [XLEN-1:0]  DBG_EXC_VEC   = 'h808,
   localparam int              IDX_W         = $clog2(XLEN)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] irq_pend_i,
   input  logic [IRQ_W-1:0] irq_en_i,
   input  logic [IRQ_W-1:0] irq_deleg_i,
   input  logic [XLEN-1:0]  exc_deleg_i,
   input  logic [1:0]       cur_priv_i,
   input  logic [XLEN-1:0]  cur_pc_i,
   input  logic             ms_mie_i,
   input  logic             ms_sie_i,
   input  logic             ms_mpie_i,
   input  logic             ms_spie_i,
   input  logic [1:0]       ms_mpp_i,
   input  logic             ms_spp_i,
   input  logic [XLEN-1:0]  mtvec_i,
   input  logic [XLEN-1:0]  stvec_i,
   input  logic             debug_mode_i,
   input  logic             ebrk_m_i,
   input  logic             ebrk_s_i,
   input  logic             ebrk_u_i,
   input  logic             exc_req_i,
   input  logic [IDX_W-1:0] exc_cause_i,
   input  logic [XLEN-1:0]  exc_tval_i,
   output logic             redirect_o,
   output logic [XLEN-1:0]  redirect_pc_o,
   output logic [1:0]       new_priv_o,
   output logic             m_wr_o,
   output logic             s_wr_o,
   output logic             dbg_wr_o,
   output logic [XLEN-1:0]  cause_o,
   output logic [XLEN-1:0]  epc_o,
   output logic [XLEN-1:0]  tval_o,
   output logic             ms_mie_o,
   output logic             ms_sie_o,
   output logic             ms_mpie_o,
   output logic             ms_spie_o,
   output logic [1:0]       ms_mpp_o,
   output logic             ms_spp_o,
   output logic [1:0]       dbg_prv_o,
   output logic [2:0]       dbg_cause_o
);

   if ((XLEN != 32) && (XLEN != 64)) begin : g_bad_xlen
      $error("trap_entry_unit: XLEN must be 32 or 64");
   end
   if ((IRQ_W <= NONSTD_BASE) || (IRQ_W > XLEN)) begin : g_bad_irq_w
      $error("trap_entry_unit: IRQ_W must exceed the last standard line and fit in XLEN");
   end

   // ---------------- selection ----------------
   logic             irq_valid;
   logic [IDX_W-1:0] irq_idx;

   irq_arbiter #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_arb (
      .pend_i  (irq_pend_i),
      .en_i    (irq_en_i),
      .deleg_i (irq_deleg_i),
      .priv_i  (cur_priv_i),
      .mie_i   (ms_mie_i),
      .sie_i   (ms_sie_i),
      .debug_i (debug_mode_i),
      .valid_o (irq_valid),
      .idx_o   (irq_idx)
   );

   logic [IDX_W-1:0] rt_idx;
   logic [XLEN-1:0]  rt_deleg, rt_pc;
   logic             rt_to_s;

   assign rt_idx   = irq_valid ? irq_idx : exc_cause_i;
   assign rt_deleg = irq_valid ? XLEN'(irq_deleg_i) : exc_deleg_i;

   trap_router #(.XLEN(XLEN), .IDX_W(IDX_W)) u_route (
      .is_irq_i (irq_valid),
      .idx_i    (rt_idx),
      .priv_i   (cur_priv_i),
      .deleg_i  (rt_deleg),
      .mtvec_i  (mtvec_i),
      .stvec_i  (stvec_i),
      .to_s_o   (rt_to_s),
      .pc_o     (rt_pc)
   );

   // ---------------- next-state decision ----------------
   logic is_brk, ebrk_hit;
   assign is_brk   = (exc_cause_i == IDX_W'(EXC_BREAK));
   assign ebrk_hit = ((cur_priv_i == PRV_M) && ebrk_m_i) ||
                     ((cur_priv_i == PRV_S) && ebrk_s_i) ||
                     ((cur_priv_i == PRV_U) && ebrk_u_i);

   logic            n_redirect, n_mw, n_sw, n_dw;
   logic [XLEN-1:0] n_pc, n_cause, n_tval;
   logic [1:0]      n_priv, n_mpp;
   logic            n_mie, n_sie, n_mpie, n_spie, n_spp;

   always_comb begin
      n_redirect = 1'b0;
      n_mw       = 1'b0;
      n_sw       = 1'b0;
      n_dw       = 1'b0;
      n_pc       = '0;
      n_priv     = cur_priv_i;
      n_cause    = '0;
      n_tval     = '0;
      n_mie      = ms_mie_i;
      n_sie      = ms_sie_i;
      n_mpie     = ms_mpie_i;
      n_spie     = ms_spie_i;
      n_mpp      = ms_mpp_i;
      n_spp      = ms_spp_i;
      if (irq_valid || exc_req_i) begin
         n_redirect = 1'b1;
         if (!irq_valid && debug_mode_i) begin
            n_pc = is_brk ? DBG_ROM_ENTRY : DBG_EXC_VEC;
         end else if (!irq_valid && is_brk && ebrk_hit) begin
            n_pc   = DBG_ROM_ENTRY;
            n_priv = PRV_M;
            n_dw   = 1'b1;
         end else begin
            n_pc    = rt_pc;
            n_cause = irq_valid ? {1'b1, {(XLEN-1-IDX_W){1'b0}}, irq_idx}
                                : XLEN'(exc_cause_i);
            n_tval  = irq_valid ? '0 : exc_tval_i;
            if (rt_to_s) begin
               n_sw   = 1'b1;
               n_priv = PRV_S;
               n_spie = ms_sie_i;
               n_spp  = cur_priv_i[0];
               n_sie  = 1'b0;
            end else begin
               n_mw   = 1'b1;
               n_priv = PRV_M;
               n_mpie = ms_mie_i;
               n_mpp  = cur_priv_i;
               n_mie  = 1'b0;
            end
         end
      end
   end

   // ---------------- output registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_o    <= 1'b0;
         m_wr_o        <= 1'b0;
         s_wr_o        <= 1'b0;
         dbg_wr_o      <= 1'b0;
         redirect_pc_o <= '0;
         new_priv_o    <= PRV_M;
         cause_o       <= '0;
         epc_o         <= '0;
         tval_o        <= '0;
         ms_mie_o      <= 1'b0;
         ms_sie_o      <= 1'b0;
         ms_mpie_o     <= 1'b0;
         ms_spie_o     <= 1'b0;
         ms_mpp_o      <= 2'b00;
         ms_spp_o      <= 1'b0;
         dbg_prv_o     <= 2'b00;
         dbg_cause_o   <= 3'd0;
      end else begin
         redirect_o <= n_redirect;
         m_wr_o     <= n_mw;
         s_wr_o     <= n_sw;
         dbg_wr_o   <= n_dw;
         if (n_redirect) begin
            redirect_pc_o <= n_pc;
            new_priv_o    <= n_priv;
         end
         if (n_mw || n_sw) begin
            cause_o   <= n_cause;
            epc_o     <= cur_pc_i;
            tval_o    <= n_tval;
            ms_mie_o  <= n_mie;
            ms_sie_o  <= n_sie;
            ms_mpie_o <= n_mpie;
            ms_spie_o <= n_spie;
            ms_mpp_o  <= n_mpp;
            ms_spp_o  <= n_spp;
         end
         if (n_dw) begin
            epc_o       <= cur_pc_i;
            dbg_prv_o   <= cur_priv_i;
            dbg_cause_o <= DBG_CAUSE_SWBP;
         end
      end
   end

   // ---------------- assertions ----------------
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_wr_o, s_wr_o, dbg_wr_o}));

   assert_strobe_has_redirect_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_o || s_wr_o || dbg_wr_o) |-> redirect_o);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(exc_req_i) && !$past(irq_valid)) |-> !redirect_o);

   assert_s_entry_from_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && s_wr_o) |-> ((new_priv_o == PRV_S) && ($past(cur_priv_i) != PRV_M)));

   assert_m_entry_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      m_wr_o |-> (!ms_mie_o && (new_priv_o == PRV_M)));

   assert_s_entry_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_wr_o |-> !ms_sie_o);

   assert_debug_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(debug_mode_i)) |-> !(m_wr_o || s_wr_o || dbg_wr_o));

   assert_target_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr_o || s_wr_o) |-> !redirect_pc_o[0]);

endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;

   localparam logic [31:0] ROM = 32'h0000_0800;
   localparam logic [31:0] EXV = 32'h0000_0808;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [15:0] pend, ien, ideleg;
   logic [31:0] edeleg, pc, mtvec, stvec, tval;
   logic [1:0]  priv, mpp;
   logic        mie, sie, mpie, spie, spp, dbg, ebm, ebs, ebu, xreq;
   logic [4:0]  xcause;

   logic        o_red, o_mw, o_sw, o_dw, o_mie, o_sie, o_mpie, o_spie, o_spp;
   logic [31:0] o_pc, o_cause, o_epc, o_tval;
   logic [1:0]  o_priv, o_mpp, o_dprv;
   logic [2:0]  o_dcause;

   trap_entry_unit i_trap_entry_unit (
      .clk(clk), .rst_n(rst_n),
      .irq_pend_i(pend), .irq_en_i(ien), .irq_deleg_i(ideleg), .exc_deleg_i(edeleg),
      .cur_priv_i(priv), .cur_pc_i(pc),
      .ms_mie_i(mie), .ms_sie_i(sie), .ms_mpie_i(mpie), .ms_spie_i(spie),
      .ms_mpp_i(mpp), .ms_spp_i(spp),
      .mtvec_i(mtvec), .stvec_i(stvec), .debug_mode_i(dbg),
      .ebrk_m_i(ebm), .ebrk_s_i(ebs), .ebrk_u_i(ebu),
      .exc_req_i(xreq), .exc_cause_i(xcause), .exc_tval_i(tval),
      .redirect_o(o_red), .redirect_pc_o(o_pc), .new_priv_o(o_priv),
      .m_wr_o(o_mw), .s_wr_o(o_sw), .dbg_wr_o(o_dw),
      .cause_o(o_cause), .epc_o(o_epc), .tval_o(o_tval),
      .ms_mie_o(o_mie), .ms_sie_o(o_sie), .ms_mpie_o(o_mpie), .ms_spie_o(o_spie),
      .ms_mpp_o(o_mpp), .ms_spp_o(o_spp), .dbg_prv_o(o_dprv), .dbg_cause_o(o_dcause)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string auto_tag;

   // expected state (reset values per R1)
   logic        e_red = 0, e_mw = 0, e_sw = 0, e_dw = 0;
   logic        e_mie = 0, e_sie = 0, e_mpie = 0, e_spie = 0, e_spp = 0;
   logic [31:0] e_pc = 0, e_cause = 0, e_epc = 0, e_tval = 0;
   logic [1:0]  e_priv = 2'd3, e_mpp = 0, e_dprv = 0;
   logic [2:0]  e_dcause = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "redirect", 32'(o_red), 32'(e_red));
      chk(tag, "m_wr", 32'(o_mw), 32'(e_mw));
      chk(tag, "s_wr", 32'(o_sw), 32'(e_sw));
      chk(tag, "dbg_wr", 32'(o_dw), 32'(e_dw));
      chk(tag, "pc", o_pc, e_pc);
      chk(tag, "priv", 32'(o_priv), 32'(e_priv));
      chk(tag, "cause", o_cause, e_cause);
      chk(tag, "epc", o_epc, e_epc);
      chk(tag, "tval", o_tval, e_tval);
      chk(tag, "mie", 32'(o_mie), 32'(e_mie));
      chk(tag, "sie", 32'(o_sie), 32'(e_sie));
      chk(tag, "mpie", 32'(o_mpie), 32'(e_mpie));
      chk(tag, "spie", 32'(o_spie), 32'(e_spie));
      chk(tag, "mpp", 32'(o_mpp), 32'(e_mpp));
      chk(tag, "spp", 32'(o_spp), 32'(e_spp));
      chk(tag, "dbg_prv", 32'(o_dprv), 32'(e_dprv));
      chk(tag, "dbg_cause", 32'(o_dcause), 32'(e_dcause));
   endtask

   // Reference model built from the requirements.
   task automatic model();
      logic        m_on, s_on, to_s;
      logic [15:0] cm, cs, cand;
      logic [31:0] tv;
      int          sel;
      int          ord [6];
      ord = '{11, 3, 7, 9, 1, 5};
      m_on = (priv != 2'd3) || mie;                         // R2
      s_on = (priv == 2'd0) || ((priv == 2'd1) && sie);     // R3
      cm   = pend & ien & ~ideleg & {16{m_on}};
      cs   = pend & ien &  ideleg & {16{s_on}};
      cand = (cm != 0) ? cm : cs;
      if (dbg) cand = 0;                                    // R4
      sel = -1;
      for (int b = 12; b < 16; b++) if (sel < 0 && cand[b]) sel = b;       // R5
      for (int k = 0; k < 6; k++)   if (sel < 0 && cand[ord[k]]) sel = ord[k];
      e_red = 0; e_mw = 0; e_sw = 0; e_dw = 0;
      auto_tag = "R12";
      if (sel >= 0) begin
         auto_tag = "R5";
         to_s = (priv <= 2'd1) && ideleg[sel];              // R7
         tv   = to_s ? stvec : mtvec;
         e_pc = {tv[31:1], 1'b0} + (tv[0] ? 32'(4 * sel) : 32'd0);   // R8
         e_cause = 32'h8000_0000 | 32'(sel);                // R6
         e_tval  = 0;
         e_epc   = pc;
         e_red   = 1;
      end else if (xreq) begin
         e_red = 1;
         if (dbg) begin                                     // R10
            auto_tag = "R10";
            e_pc = (xcause == 5'd3) ? ROM : EXV;
            e_priv = priv;
            return;
         end
         if (xcause == 5'd3 && ((priv == 2'd3 && ebm) || (priv == 2'd1 && ebs) ||
                                (priv == 2'd0 && ebu))) begin   // R11
            auto_tag = "R11";
            e_dw = 1; e_pc = ROM; e_priv = 2'd3; e_epc = pc;
            e_dprv = priv; e_dcause = 3'd1;
            return;
         end
         auto_tag = "R7";
         to_s = (priv <= 2'd1) && edeleg[xcause];
         tv   = to_s ? stvec : mtvec;
         e_pc = {tv[31:1], 1'b0};
         e_cause = 32'(xcause);
         e_tval  = tval;
         e_epc   = pc;
      end else begin
         return;
      end
      // R9 stacking
      e_mie = mie; e_sie = sie; e_mpie = mpie; e_spie = spie; e_mpp = mpp; e_spp = spp;
      if (to_s) begin
         e_sw = 1; e_priv = 2'd1; e_spie = sie; e_spp = priv[0]; e_sie = 0;
      end else begin
         e_mw = 1; e_priv = 2'd3; e_mpie = mie; e_mpp = priv; e_mie = 0;
      end
   endtask

   task automatic step(input string tag);
      model();
      @(negedge clk);
      compare((tag == "") ? auto_tag : tag);
   endtask

   task automatic clr();
      pend = 0; ien = 16'hFFFF; ideleg = 0; edeleg = 0; pc = 32'h0000_0400;
      mtvec = 32'h0000_1000; stvec = 32'h0000_2000; tval = 0;
      priv = 2'd3; mpp = 0; mie = 0; sie = 0; mpie = 0; spie = 0; spp = 0;
      dbg = 0; ebm = 0; ebs = 0; ebu = 0; xreq = 0; xcause = 0;
   endtask

   initial begin
      clr();
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;

      // R2 machine-level enable
      pend = 16'h0080; mie = 0; priv = 2'd3; step("R2");
      mie = 1;                                step("R2");
      mie = 0; priv = 2'd0;                   step("R2");
      // R3 supervisor candidates only without machine candidates
      clr(); priv = 2'd1; sie = 1; pend = 16'h0082; ideleg = 16'h0002; step("R3");
      pend = 16'h0002;                                            step("R3");
      sie = 0;                                                    step("R3");
      priv = 2'd3; mie = 1; sie = 1;                              step("R3");
      // R4 debug masks interrupts
      clr(); dbg = 1; priv = 2'd0; pend = 16'hFFFF; step("R4");
      // R5 priority
      clr(); priv = 2'd0;
      pend = 16'h6800; step("R5");
      pend = 16'h02AA; step("R5");
      pend = 16'h02A0; step("R5");
      pend = 16'h0222; step("R5");
      pend = 16'h0022; step("R5");
      pend = 16'h0020; step("R5");
      pend = 16'h0555; step("R5");
      // R8 vectoring
      clr(); priv = 2'd0; mtvec = 32'h0000_1001; pend = 16'h0800; step("R8");
      pend = 0; xreq = 1; xcause = 5'd2;                         step("R8");
      xreq = 0; stvec = 32'h0000_2001; ideleg = 16'h0002; pend = 16'h0002; step("R8");
      // R6 exception fields
      clr(); xreq = 1; xcause = 5'd5; tval = 32'h0000_DEAD; pc = 32'h0000_0444; step("R6");
      // R7 routing
      clr(); xreq = 1; xcause = 5'd8; edeleg = 32'h0000_0100; priv = 2'd0; step("R7");
      priv = 2'd3;                                                         step("R7");
      // R9 stacking
      clr(); priv = 2'd1; mie = 1; sie = 1; xreq = 1; xcause = 5'd2; step("R9");
      priv = 2'd0; edeleg = 32'h0000_0004; mpp = 2'd3; mpie = 1;     step("R9");
      // R10 debug-mode exceptions
      clr(); dbg = 1; xreq = 1; xcause = 5'd3; priv = 2'd0; step("R10");
      xcause = 5'd2;                                        step("R10");
      // R11 breakpoint into debug
      clr(); priv = 2'd0; ebu = 1; xreq = 1; xcause = 5'd3; pc = 32'h0000_0888; step("R11");
      ebu = 0;                                                                 step("R11");
      priv = 2'd1; ebs = 1;                                                    step("R11");
      // R12 timing and precedence
      clr(); priv = 2'd0; pend = 16'h0080; xreq = 1; xcause = 5'd2; step("R12");
      clr();                                                        step("R12");
      xreq = 1; xcause = 5'd4;                                      step("R12");
      step("R12");
      xreq = 0;                                                     step("R12");

      // constrained random
      void'($urandom(32'd20240611));
      for (int n = 0; n < 2000; n++) begin
         int r;
         pend   = 16'($urandom & $urandom);
         ien    = 16'($urandom | $urandom);
         ideleg = 16'($urandom);
         edeleg = $urandom;
         r      = int'($urandom % 3);
         priv   = (r == 2) ? 2'd3 : 2'(r);
         mie = 1'($urandom); sie = 1'($urandom); mpie = 1'($urandom); spie = 1'($urandom);
         mpp = 2'($urandom); spp = 1'($urandom);
         mtvec = $urandom; stvec = $urandom; pc = $urandom & 32'hFFFF_FFFC;
         dbg = (($urandom % 8) == 0);
         ebm = 1'($urandom); ebs = 1'($urandom); ebu = 1'($urandom);
         xreq = 1'($urandom);
         xcause = (($urandom % 3) == 0) ? 5'd3 : 5'($urandom % 16);
         tval = $urandom;
         step("");
      end

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R12 watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule